// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block caches page-table entries so that a 14-bit virtual address can become a 12-bit physical address without a table walk. Pages are 64 bytes, so the low six address bits are a page offset and pass straight through. The eight-bit virtual page number is split into a two-bit set index and a six-bit tag. The entry array has 16 entries, arranged as 4 sets of 4 ways. Each entry holds a tag, a six-bit physical page number and a valid flag.

A lookup is a one-cycle strobe carrying a virtual address. The tag compare is combinational, and the hit flag and the physical address appear registered on the following cycle together with a result strobe. There is no back-pressure. The block accepts a lookup every cycle, and each result is presented for exactly one cycle, so a consumer must take it when the result strobe is high. When a lookup misses, the surrounding logic walks the page tables and later pushes the entry in through the fill port. The fill port names only the set; the block picks the way itself. A flush input invalidates every entry at once.

Top module: `xlat_buf`

## Requirements
- R1: After reset, res_valid, res_hit and res_paddr are 0, and every lookup misses until a valid entry has been filled.
- R2: res_valid is high exactly in the cycle after a cycle with lk_valid high. A lookup is accepted every cycle.
- R3: The set is lk_vaddr[7:6] and the tag is lk_vaddr[13:8]. Fills go to set fill_set with tag fill_tag.
- R4: A lookup hits when the indexed set holds a valid entry whose tag equals the address tag. res_paddr is then {stored page number, lk_vaddr[5:0]}.
- R5: A lookup that misses returns res_hit = 0 and res_paddr = 0.
- R6: A fill writes the lowest-numbered way of fill_set whose valid flag is clear, when such a way exists.
- R7: When all four ways of the set are valid, a fill writes the way named by that set's two-bit rotating pointer. The pointer starts at 0 after reset and advances by one, modulo 4, only after such a fill.
- R8: The valid flag written is fill_valid. A fill with fill_valid = 0 into a full set invalidates the way it selects, and that set's pointer still advances.
- R9: flush clears every valid flag in one cycle. A fill in the same cycle as flush is dropped and does not move any pointer.
- R10: A lookup in the same cycle as a fill, a flush, or both sees the entries as they were before that cycle's write.
- R11: At most one way of a set matches a lookup tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| lk_valid | input | 1 | Lookup strobe |
| lk_vaddr | input | 14 | Virtual address to translate |
| res_valid | output | 1 | Result strobe, one cycle after lk_valid |
| res_hit | output | 1 | Lookup found a matching valid entry |
| res_paddr | output | 12 | Translated physical address, 0 on a miss |
| fill_en | input | 1 | Write one entry |
| fill_set | input | 2 | Set receiving the entry |
| fill_tag | input | 6 | Tag of the new entry |
| fill_ppn | input | 6 | Physical page number of the new entry |
| fill_valid | input | 1 | Valid flag to store with the entry |
| flush | input | 1 | Invalidate all entries |

## Verification
The single-match check assumes that software never fills a tag that is already valid in the same set. The stimulus keeps to this rule by taking every fill tag from a counter that advances by one per fill, and no set receives anywhere near 64 fills. The way-choice check assumes that fill_set is stable while fill_en is high. The bench drives all fill inputs together at the falling edge, so this holds. Lookups sweep all 256 page numbers after each stage of filling, and the expected result of every lookup is computed from a small model of sets, ways and pointers.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int DEF_VA_W  = 14;
  localparam int DEF_PA_W  = 12;
  localparam int DEF_OFF_W = 6;
  localparam int DEF_SETS  = 4;
  localparam int DEF_WAYS  = 4;
endpackage

// File: rtl/xlat_store.sv
module xlat_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int PPN_W = 6,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_set,
  input  logic [WAY_W-1:0]       wr_way,
  input  logic [TAG_W-1:0]       wr_tag,
  input  logic [PPN_W-1:0]       wr_ppn,
  input  logic                   wr_val,
  input  logic [IDX_W-1:0]       rd_set,
  output logic [WAYS*TAG_W-1:0]  rd_tags,
  output logic [WAYS*PPN_W-1:0]  rd_ppns,
  output logic [WAYS-1:0]        rd_vals,
  output logic [WAYS-1:0]        wr_set_vals
);
  localparam int ROW_T = WAYS*TAG_W;
  localparam int ROW_P = WAYS*PPN_W;

  logic [SETS*WAYS-1:0]  val_all;
  logic [SETS*ROW_T-1:0] tag_all;
  logic [SETS*ROW_P-1:0] ppn_all;
  logic [SETS-1:0]       set_busy;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS-1:0]  val_q;
    logic [ROW_T-1:0] tag_q;
    logic [ROW_P-1:0] ppn_q;
    logic             sel;

    assign sel = wr_en && !flush && (wr_set == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n)      val_q <= '0;
      else if (flush)  val_q <= '0;
      else if (sel)    val_q[wr_way] <= wr_val;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[wr_way*TAG_W +: TAG_W] <= wr_tag;
        ppn_q[wr_way*PPN_W +: PPN_W] <= wr_ppn;
      end
    end

    assign val_all[s*WAYS +: WAYS]   = val_q;
    assign tag_all[s*ROW_T +: ROW_T] = tag_q;
    assign ppn_all[s*ROW_P +: ROW_P] = ppn_q;
    assign set_busy[s]               = |val_q;
  end

  assign rd_tags     = tag_all[rd_set*ROW_T +: ROW_T];
  assign rd_ppns     = ppn_all[rd_set*ROW_P +: ROW_P];
  assign rd_vals     = val_all[rd_set*WAYS +: WAYS];
  assign wr_set_vals = val_all[wr_set*WAYS +: WAYS];

  // R9: a flush leaves no valid entry anywhere on the next cycle
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (set_busy == '0));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_go,
  input  logic [IDX_W-1:0] fill_set,
  input  logic [WAYS-1:0]  set_vals,
  output logic [WAY_W-1:0] way
);
  logic [SETS*WAY_W-1:0] ptr_all;
  logic [WAY_W-1:0]      pick;
  logic                  free_found;

  always_comb begin
    free_found = 1'b0;
    pick       = ptr_all[fill_set*WAY_W +: WAY_W];
    for (int w = WAYS-1; w >= 0; w--) begin
      if (!set_vals[w]) begin
        pick       = WAY_W'(w);
        free_found = 1'b1;
      end
    end
  end

  assign way = pick;

  for (genvar s = 0; s < SETS; s++) begin : g_ptr
    logic [WAY_W-1:0] ptr_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        ptr_q <= '0;
      else if (fill_go && !free_found && (fill_set == IDX_W'(s)))
        ptr_q <= ptr_q + 1'b1;
    end
    assign ptr_all[s*WAY_W +: WAY_W] = ptr_q;
  end

  // R6: with a free way present, a fill never lands on an occupied one
  a_r6_free_way_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && !(&set_vals)) |-> !set_vals[way]);
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int PPN_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TAG_W-1:0]      tag,
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [WAYS*PPN_W-1:0] ppns,
  input  logic [WAYS-1:0]       vals,
  output logic                  hit,
  output logic [PPN_W-1:0]      ppn
);
  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vals[w] && (tags[w*TAG_W +: TAG_W] == tag);
  end

  always_comb begin
    ppn = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) ppn = ppn | ppns[w*PPN_W +: PPN_W];
  end

  assign hit = |hit_vec;

  // R11: never more than one way of the indexed set matches
  a_r11_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xlat_pkg::*;
#(
  parameter int VA_W  = DEF_VA_W,
  parameter int PA_W  = DEF_PA_W,
  parameter int OFF_W = DEF_OFF_W,
  parameter int SETS  = DEF_SETS,
  parameter int WAYS  = DEF_WAYS,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int VPN_W = VA_W - OFF_W,
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             res_valid,
  output logic             res_hit,
  output logic [PA_W-1:0]  res_paddr,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_set,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_valid,
  input  logic             flush
);
  logic [OFF_W-1:0]      lk_off;
  logic [IDX_W-1:0]      lk_set;
  logic [TAG_W-1:0]      lk_tag;
  logic [WAYS*TAG_W-1:0] rd_tags;
  logic [WAYS*PPN_W-1:0] rd_ppns;
  logic [WAYS-1:0]       rd_vals;
  logic [WAYS-1:0]       fs_vals;
  logic [WAY_W-1:0]      fill_way;
  logic                  fill_go;
  logic                  m_hit;
  logic [PPN_W-1:0]      m_ppn;

  assign lk_off  = lk_vaddr[OFF_W-1:0];
  assign lk_set  = lk_vaddr[OFF_W +: IDX_W];
  assign lk_tag  = lk_vaddr[VA_W-1 -: TAG_W];
  assign fill_go = fill_en && !flush;

  xlat_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(fill_go), .wr_set(fill_set), .wr_way(fill_way),
    .wr_tag(fill_tag), .wr_ppn(fill_ppn), .wr_val(fill_valid),
    .rd_set(lk_set), .rd_tags(rd_tags), .rd_ppns(rd_ppns), .rd_vals(rd_vals),
    .wr_set_vals(fs_vals)
  );

  xlat_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n), .fill_go(fill_go), .fill_set(fill_set),
    .set_vals(fs_vals), .way(fill_way)
  );

  xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_match (
    .clk(clk), .rst_n(rst_n), .tag(lk_tag), .tags(rd_tags), .ppns(rd_ppns),
    .vals(rd_vals), .hit(m_hit), .ppn(m_ppn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_paddr <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && m_hit;
      res_paddr <= (lk_valid && m_hit) ? {m_ppn, lk_off} : '0;
    end
  end

  // R2: one result strobe per lookup, exactly one cycle later
  a_r2_result_timing: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (res_valid == $past(lk_valid)));
  // R5: a miss drives a zero address
  a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> (res_paddr == '0));
  // R4: a hit keeps the page offset of the address that was looked up
  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));
endmodule

// File: tb/xlat_buf_tb.sv
module xlat_buf_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [13:0] lk_vaddr = '0;
  logic        res_valid, res_hit;
  logic [11:0] res_paddr;
  logic        fill_en = 1'b0;
  logic [1:0]  fill_set = '0;
  logic [5:0]  fill_tag = '0;
  logic [5:0]  fill_ppn = '0;
  logic        fill_valid = 1'b0;
  logic        flush = 1'b0;

  int compares = 0;
  int mismatches = 0;
  bit done = 1'b0;
  logic [5:0] seed = 6'd1;

  logic [5:0] m_tag [4][4];
  logic [5:0] m_ppn [4][4];
  logic       m_val [4][4];
  logic [1:0] m_ptr [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_buf u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .res_valid(res_valid), .res_hit(res_hit), .res_paddr(res_paddr),
    .fill_en(fill_en), .fill_set(fill_set), .fill_tag(fill_tag),
    .fill_ppn(fill_ppn), .fill_valid(fill_valid), .flush(flush)
  );

  task automatic check(input string req, input logic [13:0] got, input logic [13:0] exp);
    compares++;
    if (got !== exp) begin
      mismatches++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [12:0] expect_of(input logic [13:0] va);
    logic [1:0] s = va[7:6];
    for (int w = 0; w < 4; w++)
      if (m_val[s][w] && m_tag[s][w] == va[13:8])
        return {1'b1, m_ppn[s][w], va[5:0]};
    return 13'd0;
  endfunction

  function automatic int victim(input int s);
    for (int w = 0; w < 4; w++) if (!m_val[s][w]) return w;
    return -1;
  endfunction

  task automatic model_fill(input int s, input logic [5:0] t, input logic [5:0] p, input logic v);
    int w = victim(s);
    if (w < 0) begin
      w = m_ptr[s];
      m_ptr[s] = m_ptr[s] + 2'd1;
    end
    m_tag[s][w] = t; m_ppn[s][w] = p; m_val[s][w] = v;
  endtask

  task automatic look(input logic [13:0] va, input string req);
    logic [12:0] e;
    @(negedge clk);
    e = expect_of(va);
    lk_valid = 1'b1; lk_vaddr = va;
    @(negedge clk);
    lk_valid = 1'b0;
    check(req, {res_valid, res_hit, res_paddr}, {1'b1, e});
  endtask

  task automatic fill(input int s, input logic v);
    @(negedge clk);
    fill_en = 1'b1; fill_set = 2'(s); fill_tag = seed; fill_ppn = seed ^ 6'h2A; fill_valid = v;
    @(negedge clk);
    fill_en = 1'b0;
    model_fill(s, seed, seed ^ 6'h2A, v);
    seed = seed + 6'd1;
  endtask

  task automatic sweep(input string req);
    for (int vpn = 0; vpn < 256; vpn++)
      look({8'(vpn), 6'(vpn * 7)}, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatches++;
      compares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compares, mismatches);
      $finish;
    end
  end

  initial begin
    logic [13:0] va_old;
    logic [12:0] e_old;
    for (int s = 0; s < 4; s++) begin
      m_ptr[s] = 2'd0;
      for (int w = 0; w < 4; w++) begin m_val[s][w] = 1'b0; m_tag[s][w] = '0; m_ppn[s][w] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", {res_valid, res_hit, res_paddr}, 14'd0);
    // R1 R5: empty buffer misses everywhere
    sweep("R1 R5 empty");
    // R2: idle cycle yields no result strobe
    @(negedge clk);
    check("R2 idle", {13'd0, res_valid}, 14'd0);
    // R6: fill two ways of every set, then all four
    for (int s = 0; s < 4; s++) begin fill(s, 1'b1); fill(s, 1'b1); end
    sweep("R3 R4 R6 half");
    for (int s = 0; s < 4; s++) begin fill(s, 1'b1); fill(s, 1'b1); end
    sweep("R3 R4 R5 R6 full");
    // R7: full sets rotate through ways 0..3 then wrap
    for (int s = 0; s < 4; s++) for (int k = 0; k < 5; k++) fill(s, 1'b1);
    sweep("R7 rotate");
    // R8: invalid fill into a full set drops the pointed way
    fill(0, 1'b0);
    sweep("R8 invalid fill");
    fill(0, 1'b1);
    sweep("R6 R8 refill hole");
    // R10: same-cycle fill and lookup of the entry being replaced
    va_old = {m_tag[1][m_ptr[1]], 2'd1, 6'h15};
    @(negedge clk);
    e_old = expect_of(va_old);
    lk_valid = 1'b1; lk_vaddr = va_old;
    fill_en = 1'b1; fill_set = 2'd1; fill_tag = seed; fill_ppn = seed ^ 6'h2A; fill_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0; fill_en = 1'b0;
    check("R10 old view", {res_valid, res_hit, res_paddr}, {1'b1, e_old});
    model_fill(1, seed, seed ^ 6'h2A, 1'b1);
    seed = seed + 6'd1;
    look(va_old, "R10 after replace");
    look({seed - 6'd1, 2'd1, 6'h3C}, "R10 new entry");
    // R9: flush with a competing fill and lookup in the same cycle
    va_old = {m_tag[2][0], 2'd2, 6'h09};
    @(negedge clk);
    e_old = expect_of(va_old);
    flush = 1'b1; lk_valid = 1'b1; lk_vaddr = va_old;
    fill_en = 1'b1; fill_set = 2'd2; fill_tag = seed; fill_ppn = 6'h11; fill_valid = 1'b1;
    @(negedge clk);
    flush = 1'b0; fill_en = 1'b0; lk_valid = 1'b0;
    check("R9 R10 lookup beside flush", {res_valid, res_hit, res_paddr}, {1'b1, e_old});
    for (int s = 0; s < 4; s++) for (int w = 0; w < 4; w++) m_val[s][w] = 1'b0;
    sweep("R9 flushed");
    // R9: the dropped fill left pointers alone; R6 lowest free after flush
    fill(3, 1'b1);
    sweep("R6 R9 after flush");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compares, mismatches);
    $finish;
  end
endmodule